// File: doc/BRIEF.md
# Signed-Digit Decimal Add/Subtract Unit

This unit adds or subtracts two unsigned multi-digit decimal operands supplied as packed BCD. Each operand is first recoded, digit by digit and without any carry, into a redundant signed-digit form in which every digit may take any value from -8 to 9. A carry-free core then combines the two recoded operands. Each digit position produces a transfer of -1, 0 or +1 into the next position up, and that position absorbs it without passing anything further. Subtraction runs on the same core: only the second operand's digit values are negated. The core's result is itself a redundant number, so the adder is fully redundant.

The redundant sum is registered. A second stage then resolves it into an ordinary sign-and-magnitude BCD result with one more digit than the operands. This is the only place where a borrow or carry ripples across digits. Operands are presented together with a valid strobe. The result appears two clock cycles later with its own strobe, and both the BCD result and the redundant form it came from are available. The operand width is set by the `DIGITS` parameter and defaults to 8.

Top module: `sd_dec_adder`

## Requirements
- R1: Each cycle in which `in_valid` is high produces exactly one cycle of `out_valid` high, two rising clock edges later. `out_valid` is low in all other cycles.
- R2: With `op_sub` = 0, the result equals A + B. It is given as `out_neg` (the sign) and `out_bcd` (the magnitude). `out_bcd` holds DIGITS+1 packed BCD digits, with digit i at bits 4i+3..4i and the least significant digit at bit 0. Operands use the same packing with DIGITS digits.
- R3: With `op_sub` = 1, the result equals A - B, and `out_neg` is high exactly when B > A. When the two operands are equal, the result is zero.
- R4: A zero result is always reported with `out_neg` low.
- R5: Every digit of `out_bcd` in a valid result lies in 0..9.
- R6: `out_sd` holds DIGITS+1 six-bit signed digits, with digit i at bits 6i+5..6i. Bit 5 weighs -8, bits 4, 3 and 2 weigh 4, 2 and 1, and bits 1 and 0 each weigh +1. The weighted sum of the digits times powers of ten equals the signed result. The top digit lies in {-1, 0, 1}, and every other digit lies in -8..9.
- R7: In a cycle with `out_valid` low, `out_neg`, `out_bcd` and `out_sd` keep the values they had in the previous cycle.
- R8: A synchronous active-high reset clears `out_valid`, `out_neg`, `out_bcd` and `out_sd` to zero, and it clears every pending operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| a_bcd | input | 4*DIGITS | Operand A, packed BCD |
| b_bcd | input | 4*DIGITS | Operand B, packed BCD |
| out_valid | output | 1 | Result strobe |
| out_neg | output | 1 | Result sign, high when negative |
| out_bcd | output | 4*(DIGITS+1) | Result magnitude, packed BCD |
| out_sd | output | 6*(DIGITS+1) | Result in the redundant signed-digit form |

## Verification
Every cycle, the assertions check the following properties:
- the two-cycle strobe relation;
- that outputs hold while no result is presented;
- that no BCD digit goes above 9;
- that the top redundant digit stays within one unit;
- that zero is never negative;
- that subtracting an operand from itself gives zero.

Whether the magnitude, the sign and the redundant digit values are numerically right can only be shown by the bench. The bench compares them against integer arithmetic over random operands and over every pairing of repeated single-digit values in both operations. It also covers all-nines and all-zeros extremes, and it checks the hold behaviour while idle inputs keep changing.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
package sd_pkg;
  localparam int SD_W = 6;

  // Digit value: bit5 = -8, bits4..2 = 4,2,1, bits1..0 = +1 each.
  function automatic logic signed [5:0] sd_val(input logic [5:0] d);
    return $signed({{2{d[5]}}, d[5:2]}) + $signed({5'b0, d[1]}) + $signed({5'b0, d[0]});
  endfunction

  // Canonical encoding of a value in -8..9.
  function automatic logic [5:0] sd_enc(input logic signed [5:0] v);
    logic signed [5:0] m;
    m = v - 6'sd2;
    if (v > 6'sd7) return {m[3:0], 2'b11};
    else return {v[3:0], 2'b00};
  endfunction
endpackage

// File: rtl/sd_bcd_recode.sv
`timescale 1ns/1ps
module sd_bcd_recode import sd_pkg::*; #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0]    bcd,
  output logic [SD_W*DIGITS-1:0] sd
);
  // One logic level per digit: 8/9 become 6/7 plus both unit bits.
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    assign d = bcd[4*i +: 4];
    assign sd[SD_W*i +: SD_W] = d[3] ? {1'b0, 2'b11, d[0], 2'b11}
                                     : {1'b0, d[2:0], 2'b00};
  end
endmodule

// File: rtl/sd_addsub_core.sv
`timescale 1ns/1ps
module sd_addsub_core import sd_pkg::*; #(
  parameter int DIGITS = 8
) (
  input  logic                       op_sub,
  input  logic [SD_W*DIGITS-1:0]     a_sd,
  input  logic [SD_W*DIGITS-1:0]     b_sd,
  output logic [SD_W*(DIGITS+1)-1:0] sum_sd
);
  // Two-bit signed transfer per position boundary.
  logic [2*(DIGITS+1)-1:0] xfer;
  assign xfer[1:0] = 2'b00;

  for (genvar i = 0; i < DIGITS; i++) begin : g_pos
    logic signed [5:0] av, bv, s, w, t, r, tin;
    assign av  = sd_val(a_sd[SD_W*i +: SD_W]);
    assign bv  = sd_val(b_sd[SD_W*i +: SD_W]);
    assign s   = op_sub ? (av - bv) : (av + bv);
    assign t   = (s >= 6'sd9) ? 6'sd1 : ((s <= -6'sd8) ? -6'sd1 : 6'sd0);
    assign w   = (s >= 6'sd9) ? (s - 6'sd10) : ((s <= -6'sd8) ? (s + 6'sd10) : s);
    assign xfer[2*(i+1) +: 2] = t[1:0];
    assign tin = {{4{xfer[2*i+1]}}, xfer[2*i +: 2]};
    assign r   = w + tin;
    assign sum_sd[SD_W*i +: SD_W] = sd_enc(r);
  end

  assign sum_sd[SD_W*DIGITS +: SD_W] = sd_enc({{4{xfer[2*DIGITS+1]}}, xfer[2*DIGITS +: 2]});
endmodule

// File: rtl/sd_to_bcd.sv
`timescale 1ns/1ps
module sd_to_bcd import sd_pkg::*; #(
  parameter int ND = 9
) (
  input  logic [SD_W*ND-1:0] sd,
  output logic               neg,
  output logic [4*ND-1:0]    bcd
);
  logic signed [5:0] c, r;
  logic [4*ND-1:0]   raw, mag;
  logic [3:0]        m;
  logic              k;

  always_comb begin
    // Pass 1: ripple borrows/carries into ten's-complement digits.
    c = '0;
    r = '0;
    raw = '0;
    for (int i = 0; i < ND; i++) begin
      r = sd_val(sd[SD_W*i +: SD_W]) + c;
      if (r < 0) begin
        r = r + 6'sd10;
        c = -6'sd1;
      end else if (r > 6'sd9) begin
        r = r - 6'sd10;
        c = 6'sd1;
      end else begin
        c = '0;
      end
      raw[4*i +: 4] = r[3:0];
    end
    neg = c[5];
    // Pass 2: ten's complement of the raw digits for a negative result.
    k = 1'b1;
    m = '0;
    mag = '0;
    for (int i = 0; i < ND; i++) begin
      m = 4'd9 - raw[4*i +: 4] + {3'b000, k};
      if (m == 4'd10) begin
        mag[4*i +: 4] = 4'd0;
        k = 1'b1;
      end else begin
        mag[4*i +: 4] = m;
        k = 1'b0;
      end
    end
    bcd = neg ? mag : raw;
  end
endmodule

// File: rtl/sd_dec_adder.sv
`timescale 1ns/1ps
module sd_dec_adder import sd_pkg::*; #(
  parameter int DIGITS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       op_sub,
  input  logic [4*DIGITS-1:0]        a_bcd,
  input  logic [4*DIGITS-1:0]        b_bcd,
  output logic                       out_valid,
  output logic                       out_neg,
  output logic [4*(DIGITS+1)-1:0]    out_bcd,
  output logic [SD_W*(DIGITS+1)-1:0] out_sd
);
  localparam int ND    = DIGITS + 1;
  localparam int OP_W  = SD_W * DIGITS;
  localparam int RES_W = SD_W * ND;

  logic [OP_W-1:0]  a_sd, b_sd;
  logic [RES_W-1:0] sum_d, sum_q;
  logic             v1;
  logic             neg_d;
  logic [4*ND-1:0]  bcd_d;

  sd_bcd_recode #(.DIGITS(DIGITS)) u_rec_a (.bcd(a_bcd), .sd(a_sd));
  sd_bcd_recode #(.DIGITS(DIGITS)) u_rec_b (.bcd(b_bcd), .sd(b_sd));

  sd_addsub_core #(.DIGITS(DIGITS)) u_core (
    .op_sub(op_sub), .a_sd(a_sd), .b_sd(b_sd), .sum_sd(sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      sum_q <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) sum_q <= sum_d;
    end
  end

  sd_to_bcd #(.ND(ND)) u_conv (.sd(sum_q), .neg(neg_d), .bcd(bcd_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_neg   <= 1'b0;
      out_bcd   <= '0;
      out_sd    <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_neg <= neg_d;
        out_bcd <= bcd_d;
        out_sd  <= sum_q;
      end
    end
  end
endmodule

// File: rtl/sd_dec_adder_chk.sv
`timescale 1ns/1ps
module sd_dec_adder_chk import sd_pkg::*; #(
  parameter int DIGITS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       op_sub,
  input logic [4*DIGITS-1:0]        a_bcd,
  input logic [4*DIGITS-1:0]        b_bcd,
  input logic                       out_valid,
  input logic                       out_neg,
  input logic [4*(DIGITS+1)-1:0]    out_bcd,
  input logic [SD_W*(DIGITS+1)-1:0] out_sd
);
  localparam int ND = DIGITS + 1;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic [ND-1:0] dig_ok;
  for (genvar i = 0; i < ND; i++) begin : g_ok
    assign dig_ok[i] = (out_bcd[4*i +: 4] <= 4'd9);
  end

  logic signed [5:0] top_v;
  assign top_v = sd_val(out_sd[SD_W*DIGITS +: SD_W]);

  logic self_sub;
  assign self_sub = in_valid && op_sub && (a_bcd == b_bcd);

  AST_STROBE_FWD: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid); // R1
  AST_STROBE_BACK: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |-> $past(in_valid, 2)); // R1
  AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(self_sub, 2)) |-> (out_bcd == '0 && !out_neg)); // R3
  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bcd == '0) |-> !out_neg); // R4
  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (&dig_ok)); // R5
  AST_TOP_DIGIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (top_v >= -6'sd1 && top_v <= 6'sd1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_bcd) && $stable(out_neg) && $stable(out_sd))); // R7
endmodule

bind sd_dec_adder sd_dec_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
  .a_bcd(a_bcd), .b_bcd(b_bcd), .out_valid(out_valid), .out_neg(out_neg),
  .out_bcd(out_bcd), .out_sd(out_sd)
);

// File: tb/sd_dec_adder_tb.sv
`timescale 1ns/1ps
module sd_dec_adder_tb_top;
  localparam int N   = 8;
  localparam int ND  = N + 1;
  localparam int IBW = 4 * N;
  localparam int OBW = 4 * ND;
  localparam int SW  = 6 * ND;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           op_sub = 1'b0;
  logic [IBW-1:0] a_bcd = '0, b_bcd = '0;
  logic           out_valid, out_neg;
  logic [OBW-1:0] out_bcd;
  logic [SW-1:0]  out_sd;

  always #2.5 clk = ~clk;

  sd_dec_adder #(.DIGITS(N)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .a_bcd(a_bcd), .b_bcd(b_bcd), .out_valid(out_valid), .out_neg(out_neg),
    .out_bcd(out_bcd), .out_sd(out_sd)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit     pend_v [4];
  longint pend_e [4];
  bit     pend_s [4];
  logic [OBW-1:0] last_bcd;
  logic           last_neg;
  logic [SW-1:0]  last_sd;

  function automatic longint bcd_val(input logic [OBW-1:0] x);
    longint v = 0;
    for (int i = ND - 1; i >= 0; i--) v = v * 10 + longint'(x[4*i +: 4]);
    return v;
  endfunction

  function automatic int sd_dig(input logic [5:0] d);
    return -8 * int'(d[5]) + 4 * int'(d[4]) + 2 * int'(d[3]) + int'(d[2]) + int'(d[1]) + int'(d[0]);
  endfunction

  function automatic longint sd_sum(input logic [SW-1:0] x);
    longint v = 0;
    for (int i = ND - 1; i >= 0; i--) v = v * 10 + longint'(sd_dig(x[6*i +: 6]));
    return v;
  endfunction

  function automatic logic [OBW-1:0] to_bcd(input longint m);
    logic [OBW-1:0] r = '0;
    longint t = m;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_slot();
    int slot = (cyc + 2) % 4;
    if (pend_v[slot]) begin
      longint ev = pend_e[slot];
      longint mag = (ev < 0) ? -ev : ev;
      bit dig_ok = 1;
      bit rng_ok = 1;
      chk(out_valid == 1'b1, "R1 result strobe", longint'(out_valid), 1);
      chk(out_bcd == to_bcd(mag), pend_s[slot] ? "R3 difference magnitude" : "R2 sum magnitude",
          bcd_val(out_bcd), mag);
      chk(out_neg == (ev < 0), pend_s[slot] ? "R3 difference sign" : "R2 sum sign",
          longint'(out_neg), longint'(ev < 0));
      if (ev == 0) chk(out_neg == 1'b0, "R4 zero is positive", longint'(out_neg), 0);
      for (int i = 0; i < ND; i++) if (out_bcd[4*i +: 4] > 4'd9) dig_ok = 0;
      chk(dig_ok, "R5 BCD digit range", bcd_val(out_bcd), mag);
      chk(sd_sum(out_sd) == ev, "R6 redundant value", sd_sum(out_sd), ev);
      for (int i = 0; i < N; i++)
        if (sd_dig(out_sd[6*i +: 6]) < -8 || sd_dig(out_sd[6*i +: 6]) > 9) rng_ok = 0;
      if (sd_dig(out_sd[6*N +: 6]) < -1 || sd_dig(out_sd[6*N +: 6]) > 1) rng_ok = 0;
      chk(rng_ok, "R6 redundant digit ranges", longint'(rng_ok), 1);
    end else begin
      chk(out_valid == 1'b0, "R1 no stray strobe", longint'(out_valid), 0);
      chk(out_bcd == last_bcd && out_neg == last_neg && out_sd == last_sd,
          "R7 idle hold", bcd_val(out_bcd), bcd_val(last_bcd));
    end
    pend_v[slot] = 0;
  endtask

  task automatic step(input bit v, input logic [IBW-1:0] a, input logic [IBW-1:0] b, input bit sub);
    @(negedge clk);
    check_slot();
    last_bcd = out_bcd;
    last_neg = out_neg;
    last_sd  = out_sd;
    in_valid = v;
    op_sub   = sub;
    a_bcd    = a;
    b_bcd    = b;
    pend_v[cyc % 4] = v;
    pend_s[cyc % 4] = sub;
    pend_e[cyc % 4] = sub ? bcd_val({4'b0, a}) - bcd_val({4'b0, b})
                          : bcd_val({4'b0, a}) + bcd_val({4'b0, b});
    cyc++;
  endtask

  function automatic logic [IBW-1:0] rep_digit(input int d);
    logic [IBW-1:0] r;
    for (int i = 0; i < N; i++) r[4*i +: 4] = 4'(d);
    return r;
  endfunction

  function automatic logic [IBW-1:0] rnd_bcd();
    logic [IBW-1:0] r;
    for (int i = 0; i < N; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) pend_v[i] = 0;
    repeat (4) @(negedge clk);
    // R8: reset values
    chk(out_valid == 1'b0 && out_neg == 1'b0, "R8 reset flags", longint'({out_valid, out_neg}), 0);
    chk(out_bcd == '0 && out_sd == '0, "R8 reset data", bcd_val(out_bcd), 0);
    last_bcd = '0;
    last_neg = 1'b0;
    last_sd  = '0;
    rst = 1'b0;

    // Directed extremes
    step(1, rep_digit(9), rep_digit(9), 0);       // R2 largest sum
    step(1, '0, rep_digit(9), 1);                 // R3 most negative
    step(1, rep_digit(9), '0, 1);                 // R3 positive
    step(1, '0, '0, 1);                           // R4 zero via subtract
    step(1, '0, '0, 0);                           // R4 zero via add
    step(0, rep_digit(5), rep_digit(3), 1);       // R7 idle with changing inputs
    step(0, rep_digit(7), rep_digit(1), 0);
    step(0, rep_digit(2), rep_digit(8), 1);
    step(1, 32'h12345678, 32'h12345678, 1);       // R3 equal operands
    step(1, 32'h00000001, 32'h10000000, 1);
    step(1, 32'h90000000, 32'h10000000, 0);

    // Every pair of repeated single-digit values, both operations
    for (int d = 0; d < 10; d++)
      for (int e = 0; e < 10; e++) begin
        step(1, rep_digit(d), rep_digit(e), 0);
        step(1, rep_digit(d), rep_digit(e), 1);
      end

    // Random back-to-back and gapped traffic
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, rnd_bcd(), rnd_bcd(), $urandom % 2 == 1);

    // Drain
    for (int k = 0; k < 4; k++) step(0, rnd_bcd(), rnd_bcd(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule